// File: doc/BRIEF.md
# Ratio-Locked Three-Way Clock Enable Generator

This block runs on a fast reference clock, which stands for a multiplier output at one to four times an external clock. From that clock it produces three single-cycle enable pulses: one for a core domain, one for a bus domain and one for a peripheral domain. Logic in each domain uses its enable to advance on a subset of fast-clock edges, so the block never gates or derives a real clock.

Software writes one 8-bit configuration word. The word holds the multiplier code and independent divide codes for the core and peripheral enables. The bus enable is not programmable: it always divides by the multiplier, so its rate equals the external clock. Any word that would run an output slower than the external clock, or that uses the reserved code, is dropped whole and sets a sticky error flag, which a read strobe clears.

Accepted settings wait in a pending register and are copied to the counters only at the start of a 12-cycle frame. Twelve is the least common multiple of every legal ratio, so at that point all phase counters wrap together and no pulse is cut short or doubled.

Top module: `clk_ratio_gen`

## Requirements
- R1: During and after reset the multiplier is x1, both programmable ratios are /1, all three enables are high on every cycle, `err_flag` is 0 and `cfg_rdata` is 0.
- R2: Bits [1:0] of the configuration word hold the multiplier code m, which selects (m+1) times the external clock. `bus_en` pulses once every (m+1) fast cycles.
- R3: Bits [4:2] hold the core divide code. Codes 0 to 6 select /1, /2, /3, /4, /6, /8 and /12. `core_en` pulses once every ratio cycles.
- R4: Bits [7:5] hold the peripheral divide code, with the same encoding as the core code. `per_en` follows this ratio independently of the core ratio.
- R5: A write is rejected whole if either divide code is 7, or if either divide ratio is larger than the multiplier (m+1). After a rejected write, `cfg_rdata` and all enable patterns are unchanged.
- R6: A rejected write sets `err_flag` on the next cycle, and the flag stays set until `err_rd` is pulsed. A pulse of `err_rd` clears the flag on the next cycle, unless a rejected write arrives in the same cycle, in which case the flag stays set.
- R7: An accepted write appears on `cfg_rdata` one cycle later. The enables change only at the next frame start; frames repeat every 12 cycles, counted from reset. If several writes arrive within one frame, the last accepted write is the one that takes effect.
- R8: In the first cycle of every frame, `core_en`, `bus_en` and `per_en` are all high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word: peripheral code [7:5], core code [4:2], multiplier code [1:0] |
| cfg_rdata | output | 8 | Last accepted configuration word |
| err_rd | input | 1 | Read strobe that clears the error flag |
| err_flag | output | 1 | Sticky flag marking a rejected write |
| core_en | output | 1 | Core-domain enable pulse |
| bus_en | output | 1 | Bus-domain enable pulse, at the external clock rate |
| per_en | output | 1 | Peripheral-domain enable pulse |

## Verification
On every cycle the assertions check four things: all three enables coincide at each frame start, the active setting never moves in the middle of a frame, the bus enable never leaves a gap longer than the largest multiplier, and the error flag keeps its sticky and clear-on-read behaviour. Only the bench scenarios show the exact pulse spacing for each ratio code and multiplier pair. They also show that a rejected word leaves the old pattern running, and that the last of several writes in one frame is the one that wins. They cover the case where a read and a rejected write arrive in the same cycle, and they trace exactly when a new ratio first appears after a write.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int MULT_W   = 2;
    localparam int CODE_W   = 3;
    localparam int MAX_MULT = 1 << MULT_W;
    localparam int RES_CODE = (1 << CODE_W) - 1;
    localparam int NUM_CH   = 3;
    localparam int CH_CORE  = 0;
    localparam int CH_BUS   = 1;
    localparam int CH_PER   = 2;

    typedef logic [MULT_W-1:0] mult_code_t;
    typedef logic [CODE_W-1:0] ratio_code_t;

    typedef struct packed {
        ratio_code_t per;
        ratio_code_t core;
        mult_code_t  mult;
    } clk_cfg_t;

    localparam int CFG_W = $bits(clk_cfg_t);
    localparam clk_cfg_t CFG_RESET = '0;

    function automatic int unsigned ratio_of(ratio_code_t c);
        case (c)
            3'd0:    return 32'd1;
            3'd1:    return 32'd2;
            3'd2:    return 32'd3;
            3'd3:    return 32'd4;
            3'd4:    return 32'd6;
            3'd5:    return 32'd8;
            3'd6:    return 32'd12;
            default: return 32'd0;
        endcase
    endfunction

    function automatic int unsigned mult_of(mult_code_t m);
        return 32'(m) + 32'd1;
    endfunction

    function automatic int unsigned gcd_u(int unsigned a, int unsigned b);
        int unsigned x;
        int unsigned y;
        int unsigned t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int unsigned frame_len();
        int unsigned l;
        l = 1;
        for (int unsigned i = 2; i <= MAX_MULT; i++) begin
            l = (l / gcd_u(l, i)) * i;
        end
        return l;
    endfunction

    localparam int FRAME = int'(frame_len());
    localparam int CNT_W = (FRAME > 1) ? $clog2(FRAME) : 1;
    localparam int PH_W  = $clog2(FRAME + 1);

    function automatic logic code_ok(ratio_code_t c, mult_code_t m);
        return (int'(c) != RES_CODE) && (ratio_of(c) <= mult_of(m));
    endfunction

    function automatic logic cfg_legal(clk_cfg_t c);
        return code_ok(c.core, c.mult) && code_ok(c.per, c.mult);
    endfunction

endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
    import clkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  clk_cfg_t wdata,
    input  logic     err_rd,
    output clk_cfg_t pend_cfg,
    output logic     err
);
    logic accept;
    logic reject;

    always_comb begin
        accept = we && cfg_legal(wdata);
        reject = we && !cfg_legal(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cfg <= CFG_RESET;
        end else if (accept) begin
            pend_cfg <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 1'b0;
        end else if (reject) begin
            err <= 1'b1;
        end else if (err_rd) begin
            err <= 1'b0;
        end
    end
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
    import clkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_cfg_t pend_cfg,
    output clk_cfg_t act_cfg,
    output logic     wrap,
    output logic     first
);
    logic [CNT_W-1:0] cnt;

    always_comb begin
        wrap  = (cnt == CNT_W'(FRAME - 1));
        first = (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            act_cfg <= CFG_RESET;
        end else if (wrap) begin
            cnt     <= '0;
            act_cfg <= pend_cfg;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/phase_ctr.sv
module phase_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wrap,
    input  logic [W-1:0] last,
    output logic         en
);
    logic [W-1:0] ctr;

    assign en = (ctr == '0);

    always_ff @(posedge clk) begin
        if (rst || wrap) begin
            ctr <= '0;
        end else if (ctr >= last) begin
            ctr <= '0;
        end else begin
            ctr <= ctr + 1'b1;
        end
    end
endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             err_rd,
    output logic             err_flag,
    output logic             core_en,
    output logic             bus_en,
    output logic             per_en
);
    clk_cfg_t pend_cfg;
    clk_cfg_t act_cfg;
    logic     wrap;
    logic     frame_first;
    logic [NUM_CH-1:0][PH_W-1:0] last_v;
    logic [NUM_CH-1:0]           en_v;

    cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .wdata    (clk_cfg_t'(cfg_wdata)),
        .err_rd   (err_rd),
        .pend_cfg (pend_cfg),
        .err      (err_flag)
    );

    frame_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .pend_cfg (pend_cfg),
        .act_cfg  (act_cfg),
        .wrap     (wrap),
        .first    (frame_first)
    );

    always_comb begin
        last_v[CH_CORE] = PH_W'(ratio_of(act_cfg.core) - 32'd1);
        last_v[CH_BUS]  = PH_W'(mult_of(act_cfg.mult) - 32'd1);
        last_v[CH_PER]  = PH_W'(ratio_of(act_cfg.per) - 32'd1);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        phase_ctr #(.W(PH_W)) u_ph (
            .clk  (clk),
            .rst  (rst),
            .wrap (wrap),
            .last (last_v[g]),
            .en   (en_v[g])
        );
    end

    assign cfg_rdata = pend_cfg;
    assign core_en   = en_v[CH_CORE];
    assign bus_en    = en_v[CH_BUS];
    assign per_en    = en_v[CH_PER];
endmodule

// File: rtl/clk_ratio_gen_chk.sv
module clk_ratio_gen_chk
    import clkdiv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             err_rd,
    input logic             err_flag,
    input logic             core_en,
    input logic             bus_en,
    input logic             per_en,
    input logic             frame_first,
    input logic [CFG_W-1:0] act_cfg
);
    logic [PH_W-1:0] bus_gap;

    always_ff @(posedge clk) begin
        if (rst || bus_en) begin
            bus_gap <= '0;
        end else begin
            bus_gap <= bus_gap + 1'b1;
        end
    end

    a_r8_frame_align: assert property (@(posedge clk) disable iff (rst)
        frame_first |-> (core_en && bus_en && per_en));

    a_r7_hold_midframe: assert property (@(posedge clk) disable iff (rst)
        !frame_first |-> $stable(act_cfg));

    a_r2_bus_gap: assert property (@(posedge clk) disable iff (rst)
        int'(bus_gap) < MAX_MULT);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_rd) |=> err_flag);

    a_r6_err_clear: assert property (@(posedge clk) disable iff (rst)
        (err_rd && !cfg_we) |=> !err_flag);

    a_r5_reject_keeps: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $stable(cfg_rdata));
endmodule

bind clk_ratio_gen clk_ratio_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_rdata   (cfg_rdata),
    .err_rd      (err_rd),
    .err_flag    (err_flag),
    .core_en     (core_en),
    .bus_en      (bus_en),
    .per_en      (per_en),
    .frame_first (frame_first),
    .act_cfg     (act_cfg)
);

// File: tb/clk_ratio_gen_tb.sv
module clk_ratio_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       err_rd = 1'b0;
    logic       err_flag;
    logic       core_en, bus_en, per_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int rt[8] = '{1, 2, 3, 4, 6, 8, 12, 0};
    int m_cnt = 0;
    logic [7:0] m_pend = 8'h00;
    logic [7:0] m_act  = 8'h00;
    bit m_err = 0;

    always #4 clk = ~clk;

    clk_ratio_gen u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .err_rd(err_rd), .err_flag(err_flag),
        .core_en(core_en), .bus_en(bus_en), .per_en(per_en)
    );

    function automatic bit legal(logic [7:0] w);
        int m = int'(w[1:0]) + 1;
        int c = int'(w[4:2]);
        int p = int'(w[7:5]);
        return (c != 7) && (p != 7) && (rt[c] <= m) && (rt[p] <= m);
    endfunction

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_cnt = 0; m_pend = 8'h00; m_act = 8'h00; m_err = 0;
        end else begin
            logic [7:0] np;
            bit ne;
            np = m_pend;
            ne = m_err;
            if (err_rd) ne = 0;
            if (cfg_we) begin
                if (legal(cfg_wdata)) np = cfg_wdata;
                else ne = 1;
            end
            if (m_cnt == 11) begin
                m_act = m_pend;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
            m_pend = np;
            m_err = ne;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(int'(bus_en),  int'((m_cnt % (int'(m_act[1:0]) + 1)) == 0), "R2 bus_en");
            chk(int'(core_en), int'((m_cnt % rt[m_act[4:2]]) == 0),          "R3 core_en");
            chk(int'(per_en),  int'((m_cnt % rt[m_act[7:5]]) == 0),          "R4 per_en");
            chk(int'(err_flag), int'(m_err),                                 "R6 err_flag");
            chk(int'(cfg_rdata), int'(m_pend),                               "R5/R7 cfg_rdata");
            if (m_cnt == 0)
                chk(int'(core_en && bus_en && per_en), 1, "R8 frame start all high");
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_err();
        @(negedge clk);
        err_rd = 1'b1;
        @(negedge clk);
        err_rd = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        wait (cycles > 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        // R1: reset state observed while reset is held
        chk(int'({core_en, bus_en, per_en}), 7, "R1 enables in reset");
        chk(int'(err_flag), 0, "R1 err in reset");
        chk(int'(cfg_rdata), 0, "R1 rdata in reset");
        rst = 1'b0;
        idle(30);
        // R2 R3 R4: x4 multiplier, core /2, peripheral /4
        wr({3'd3, 3'd1, 2'd3});
        idle(40);
        // R7: two writes within one frame, the last one wins
        wr({3'd0, 3'd3, 2'd3});
        wr({3'd1, 3'd2, 2'd3});
        idle(40);
        // R3 R4: x3 with core /3 and peripheral /1
        wr({3'd0, 3'd2, 2'd2});
        idle(30);
        // R5: core /3 with x2 is rejected
        wr({3'd0, 3'd2, 2'd1});
        idle(30);
        // R6: flag stays set until read, read clears it
        rd_err();
        idle(5);
        // R5: reserved code 7 rejected
        wr({3'd7, 3'd0, 2'd3});
        idle(5);
        // R5: /6 with x4 rejected; R6: read in the same cycle as a reject keeps flag
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = {3'd0, 3'd4, 2'd3}; err_rd = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; err_rd = 1'b0;
        idle(20);
        rd_err();
        // R2: back to x1 everything /1, then x2 with /2 /1
        wr(8'h00);
        idle(25);
        wr({3'd0, 3'd1, 2'd1});
        idle(30);
        // R1: reset again restores defaults
        @(negedge clk); rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(15);
        finish_run();
    end
endmodule